// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switcher

This block picks which of two free-running clocks drives the system clock. It moves from one source to the other without producing a runt pulse. Source 0 is the internal clock and source 1 is the configured primary clock. A one-bit select input names the wanted source, and each source has a ready input. A switch begins when the select points away from the source now in use. It does not go ahead until the wanted source reports ready. Until then the output keeps toggling from the old clock.

The switch itself is a fixed, edge-counted handover. The request to give up the old clock is sampled on two rising edges of the old clock. The old gate then closes on the next falling edge of the old clock, and from that edge the output stays low. Next, the fact that the old gate is closed is sampled on two rising edges of the new clock. The new gate opens on the following falling edge of the new clock, so the first output pulse is a full high phase of the new clock.

Each source has its own two-state gate machine, clocked on its own falling edge. The states are `SL_CLOSED` and `SL_OPEN`. The transition *grant* goes from `SL_CLOSED` to `SL_OPEN`. It is taken when the source is selected, the source is ready and the other gate has been seen closed. The transition *release* goes from `SL_OPEN` to `SL_CLOSED`. It is taken when the other source is selected and ready. Every control signal that crosses between the two clock domains passes through a synchronizer of two or more flops. The oscillators, their start-up counting and any frequency multiplier are outside this block. The ready inputs stand in for them.

Top module: `gfsw_switch`

## Requirements
- R1: After reset the source named by `INIT_SRC` (default 0, `clk_int`) drives `clk_sys` at once, and `pri_active` is 0.
- R2: While the selected source is not ready, `clk_sys` keeps following the source already in use, for as long as the ready input stays low.
- R3: Once the other source is both selected and ready, the old clock passes exactly two more rising edges to `clk_sys`. The output is then held low from the falling edge of the old clock that follows the second of those edges.
- R4: The low hold ends when the new gate opens on a falling edge of the new clock, after at least two rising edges of the new clock. The hold lasts between two and four periods of the new clock, and the first pulse after it is a high phase of the new clock.
- R5: The two gates are never open at the same time. Every high and low phase of `clk_sys` lasts at least half of the shorter source period, so no runt pulses appear.
- R6: `pri_active` is 1 exactly while the primary source (`clk_pri`, select value 1) is gated to `clk_sys`. It is 0 while the internal source is gated and during the low hold.
- R7: When a switch to the primary source completes, `clk_sys` follows `clk_pri` edge for edge.
- R8: A switch back to the internal source (select value 0) follows the same sequence once `rdy_int` is high. The ready level of the source being left has no effect on a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal source clock (select value 0) |
| clk_pri | input | 1 | Primary source clock (select value 1) |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Wanted source: 0 internal, 1 primary |
| rdy_int | input | 1 | Internal source is stable |
| rdy_pri | input | 1 | Primary source is stable |
| clk_sys | output | 1 | Switched system clock |
| pri_active | output | 1 | 1 while the primary source is gated to `clk_sys` |

## Verification
The switcher is driven with select and ready combinations in both directions. These include a switch requested while its target is not ready, which must leave the output on the old clock. They also include a ready drop on the source being left, which must change nothing, and a complete return to the internal clock. The two clocks have unrelated periods and phases. A waveform match against each clock tells which source is really gated, and it separates that from what the status bit reports. A directed handover raises ready just after an old-clock falling edge. It then counts the old-clock pulses that still reach the output and times the low hold against the new-clock period. A pulse-width monitor running through the whole run flags any runt high or low phase.

// File: rtl/gfsw_pkg.sv
`timescale 1ns/100ps
package gfsw_pkg;
    // Gate state of one clock source slice
    typedef enum logic {
        SL_CLOSED = 1'b0,
        SL_OPEN   = 1'b1
    } gate_state_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/gfsw_sync.sv
`timescale 1ns/100ps
// Multi-flop level synchronizer into the clk domain.
module gfsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("gfsw_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/gfsw_slice.sv
`timescale 1ns/100ps
// Per-source gate machine: requests are synchronized on rising edges,
// the gate state moves only on falling edges of its own clock.
module gfsw_slice
    import gfsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit INIT_OPEN   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic leave_req,     // other source wanted and ready (async)
    input  logic join_req,      // this source wanted and ready (async)
    input  logic other_closed,  // gate of other source is closed (async)
    output logic gate
);
    localparam gate_state_e RESET_STATE = INIT_OPEN ? SL_OPEN : SL_CLOSED;

    logic leave_s, join_s, oc_s;
    gate_state_e state_q, state_d;

    gfsw_sync #(.STAGES(SYNC_STAGES)) u_sync_leave (
        .clk(clk), .rst_n(rst_n), .d(leave_req), .q(leave_s));
    gfsw_sync #(.STAGES(SYNC_STAGES)) u_sync_join (
        .clk(clk), .rst_n(rst_n), .d(join_req), .q(join_s));
    gfsw_sync #(.STAGES(SYNC_STAGES)) u_sync_other (
        .clk(clk), .rst_n(rst_n), .d(other_closed), .q(oc_s));

    // Next-state logic: release and grant transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_OPEN:   if (leave_s)                       state_d = SL_CLOSED;
            SL_CLOSED: if (join_s && oc_s && !leave_s)    state_d = SL_OPEN;
            default:                                      state_d = SL_CLOSED;
        endcase
    end

    // State register, falling edge so the gate changes while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        gate = (state_q == SL_OPEN);
    end
endmodule

// File: rtl/gfsw_switch.sv
`timescale 1ns/100ps
module gfsw_switch
    import gfsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INIT_SRC    = 0
) (
    input  logic clk_int,
    input  logic clk_pri,
    input  logic rst_n,
    input  logic src_sel,
    input  logic rdy_int,
    input  logic rdy_pri,
    output logic clk_sys,
    output logic pri_active
);
    logic [NUM_SRC-1:0] clk_v, rdy_v, want_v, gate_v;

    assign clk_v  = {clk_pri, clk_int};
    assign rdy_v  = {rdy_pri, rdy_int};
    assign want_v = {src_sel, ~src_sel};

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            localparam int OTHER = NUM_SRC - 1 - i;
            gfsw_slice #(
                .SYNC_STAGES (SYNC_STAGES),
                .INIT_OPEN   (i == INIT_SRC)
            ) u_slice (
                .clk          (clk_v[i]),
                .rst_n        (rst_n),
                .leave_req    (~want_v[i] & rdy_v[OTHER]),
                .join_req     (want_v[i] & rdy_v[i]),
                .other_closed (~gate_v[OTHER]),
                .gate         (gate_v[i])
            );
        end
    endgenerate

    assign clk_sys    = |(clk_v & gate_v);
    assign pri_active = gate_v[1];
endmodule

// File: rtl/gfsw_switch_chk.sv
`timescale 1ns/100ps
module gfsw_switch_chk (
    input logic clk_int,
    input logic clk_pri,
    input logic rst_n,
    input logic src_sel,
    input logic rdy_int,
    input logic rdy_pri,
    input logic clk_sys,
    input logic pri_active,
    input logic gate_int,
    input logic gate_pri
);
    // R5: gates mutually exclusive
    always_comb begin
        if (rst_n) begin
            a_r5_exclusive: assert (!(gate_int && gate_pri));
        end
    end

    // R1: an open internal gate passes its high phase
    a_r1_old_drives: assert property (@(negedge clk_int) disable iff (!rst_n)
        gate_int |-> clk_sys);

    // R4: output held low while both gates are closed
    a_r4_hold_low: assert property (@(posedge clk_pri) disable iff (!rst_n)
        (!gate_int && !gate_pri) |-> !clk_sys);

    // R6: status high means primary high phase reaches the output
    a_r6_status: assert property (@(negedge clk_pri) disable iff (!rst_n)
        pri_active |-> clk_sys);

    // R3: internal gate closes only on a ready primary request
    a_r3_close_needs_request: assert property (@(negedge clk_int) disable iff (!rst_n)
        $fell(gate_int) |-> (src_sel && rdy_pri));

    // R8: primary gate closes only on a ready internal request
    a_r8_close_needs_request: assert property (@(negedge clk_pri) disable iff (!rst_n)
        $fell(gate_pri) |-> (!src_sel && rdy_int));
endmodule

bind gfsw_switch gfsw_switch_chk chk_i (
    .clk_int    (clk_int),
    .clk_pri    (clk_pri),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .rdy_int    (rdy_int),
    .rdy_pri    (rdy_pri),
    .clk_sys    (clk_sys),
    .pri_active (pri_active),
    .gate_int   (gate_v[0]),
    .gate_pri   (gate_v[1])
);

// File: tb/gfsw_switch_tb_top.sv
`timescale 1ns/100ps
module gfsw_switch_tb_top;
    logic clk_int, clk_pri, rst_n, src_sel, rdy_int, rdy_pri;
    logic clk_sys, pri_active;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    gfsw_switch dut_i (
        .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n),
        .src_sel(src_sel), .rdy_int(rdy_int), .rdy_pri(rdy_pri),
        .clk_sys(clk_sys), .pri_active(pri_active)
    );

    // 250 MHz internal clock, 100 MHz primary with unrelated phase
    initial begin clk_int = 0; forever #2 clk_int = ~clk_int; end
    initial begin clk_pri = 0; #1.3; forever #5 clk_pri = ~clk_pri; end

    // Pulse monitor (R5)
    int rise_cnt = 0;
    int runts = 0;
    realtime t_rise = 0, t_fall = 0;
    bit have_rise = 0, have_fall = 0;
    always @(posedge clk_sys) begin
        rise_cnt++;
        if (rst_n && have_fall && ($realtime - t_fall) < 1.9) runts++;
        t_rise = $realtime; have_rise = 1;
    end
    always @(negedge clk_sys) begin
        if (rst_n && have_rise && ($realtime - t_rise) < 1.9) runts++;
        t_fall = $realtime; have_fall = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic follows(input bit src, input string tag);
        int bad = 0;
        for (int k = 0; k < 4; k++) begin
            if (src) @(posedge clk_pri); else @(posedge clk_int);
            #0.5; if (clk_sys !== 1'b1) bad++;
            if (src) @(negedge clk_pri); else @(negedge clk_int);
            #0.5; if (clk_sys !== 1'b0) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    // {src_sel, rdy_int, rdy_pri, expected source}
    localparam logic [3:0] VEC [9] = '{
        4'b0_1_1_0,   // stay internal (R1)
        4'b1_1_0_0,   // primary wanted, not ready (R2)
        4'b1_1_1_1,   // switch to primary (R7)
        4'b1_0_1_1,   // old ready dropped, no effect (R8)
        4'b0_0_1_1,   // internal wanted, not ready (R2)
        4'b0_1_1_0,   // back to internal (R8)
        4'b0_1_0_0,   // primary not ready, irrelevant
        4'b1_1_1_1,   // to primary again (R7)
        4'b0_1_1_0    // to internal again (R8)
    };

    initial begin
        realtime t0, gap;
        int c0;
        rst_n = 0; src_sel = 0; rdy_int = 1; rdy_pri = 0;
        #21;
        // R1: reset state
        check(pri_active === 1'b0, "R1 status in reset", pri_active, 0);
        rst_n = 1;
        #40;
        check(pri_active === 1'b0, "R1 status after reset", pri_active, 0);
        follows(1'b0, "R1 internal drives after reset");

        // Vector table
        foreach (VEC[v]) begin
            {src_sel, rdy_int, rdy_pri} = VEC[v][3:1];
            #300;
            check(pri_active === VEC[v][0], $sformatf("R6 status vector %0d", v),
                  pri_active, VEC[v][0]);
            follows(VEC[v][0], $sformatf("R7 waveform vector %0d", v));
        end

        // Directed handover timing (R2, R3, R4)
        src_sel = 0; rdy_int = 1; rdy_pri = 0;
        #200;
        src_sel = 1;
        #400;
        follows(1'b0, "R2 stays on old while new not ready");
        check(pri_active === 1'b0, "R2 status unchanged", pri_active, 0);
        @(negedge clk_int); #1;
        t0 = $realtime; c0 = rise_cnt;
        rdy_pri = 1;
        #7.5;
        check(rise_cnt - c0 == 2, "R3 old edges after ready", rise_cnt - c0, 2);
        check(clk_sys === 1'b0, "R3 output held low", clk_sys, 0);
        @(posedge clk_sys);
        gap = $realtime - t_fall;
        #0.3;
        check(clk_pri === 1'b1, "R4 first pulse from new clock", clk_pri, 1);
        check(gap >= 19.0 && gap <= 41.0, "R4 hold length ns", int'(gap), 30);
        check(pri_active === 1'b1, "R6 status after handover", pri_active, 1);
        follows(1'b1, "R7 follows primary after handover");

        // R5: pulse widths over the whole run
        check(runts == 0, "R5 runt pulses", runts, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all): actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule